// File: doc/BRIEF.md
# Fault Cause Classifier

This block decides what happens when the processor enters its fault handler. On a start strobe it samples four primary error flags (stack overflow, control-store parity, register-file parity, memory error), the detail bits of the memory error, a 16-bit control word, the running task number, the task number of the reference that faulted, the faulting virtual page and that page's dirty flag. It then picks one of three outcomes: resume the interrupted task, notify the emulator task with an encoded fault parameter, or crash with a numeric code.

The decision uses fixed priorities. A memory error with no other primary flag is the time-critical case and is decoded first. Inside the memory path the order is out-of-bounds, then high-half parity, then the detail bits of the two memory-control stages. Crash codes are formed by adding a task number or a flag field to a fixed base. The fault parameter uses a signed encoding. Page faults are positive. Write-protect faults are negative. The all-ones value is reserved for out-of-bounds and cannot alias a write-protect fault on the highest page.

Top module: `fault_classifier`

## Requirements
- R1: `valid_o` is high for exactly the one cycle after a cycle in which `start_i` is high. `act_o`, `code_o`, `param_o` and `emu_run_o` keep their values until the next start. After reset, `valid_o`=0, `act_o`=0 and `code_o`=0.
- R2: The action encoding is 0 = resume, 1 = notify emulator, 2 = crash. A memory error takes the memory path only when stack, control-store parity and register parity are all clear. Stack overflow together with a memory error is handled as a stack error.
- R3: With all four primary flags clear, the outcome is a crash with code 40 + current task.
- R4: Any control-store or register-file parity flag gives a crash with code 48 + F. F is the 4-bit field {stack, cs parity, rf parity, mem}, with stack in bit 3.
- R5: A stack error with no parity flag notifies with parameter 16'h4000 when `ctrl_i[15]`=1. When `ctrl_i[15]`=0 it crashes with code 64.
- R6: In the memory path, out-of-bounds notifies with parameter 16'hFFFF when `ctrl_i[15]`=1. Otherwise it crashes with code 80 + current task. Out-of-bounds takes precedence over high-half parity.
- R7: High-half parity without out-of-bounds resumes when `ctrl_i[2]`=0 and crashes with code 96 + current task when `ctrl_i[2]`=1.
- R8: If the memory path has neither out-of-bounds nor high-half parity, any second-stage bit together with any first-stage bit crashes with code 112. A second-stage bit alone crashes with code 240 + faulting task.
- R9: A first-stage fault crashes with code 220 + faulting task when the faulting task is not 0 or when `ctrl_i[15]`=0.
- R10: A first-stage fault from task 0 with `ctrl_i[15]`=1 notifies. A clear dirty flag gives parameter {2'b00, page}, a page fault. A set dirty flag gives {2'b10, page}, a write-protect fault. Page 14'h3FFF write-protect therefore gives 16'hBFFF.
- R11: A memory path with no detail bit set crashes with code 250.
- R12: `emu_run_o` is 1 exactly when the current task sampled at start was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sample inputs and classify |
| stk_err_i | input | 1 | Stack overflow/underflow flag |
| cs_par_i | input | 1 | Control-store parity flag |
| rf_par_i | input | 1 | Register-file parity flag |
| mem_err_i | input | 1 | Combined memory error flag |
| oob_i | input | 1 | Memory address out of bounds |
| hi_par_i | input | 1 | High-half memory word parity |
| s2_err_i | input | 2 | Second-stage memory error bits |
| s1_err_i | input | 2 | First-stage (page/write-protect) fault bits |
| ctrl_i | input | 16 | Control word; bit 2 = crash on high-half parity, bit 15 = notify enable |
| cur_task_i | input | 4 | Task running at fault entry |
| flt_task_i | input | 4 | Task that issued the faulting reference |
| page_i | input | 14 | Faulting virtual page |
| dirty_i | input | 1 | Dirty flag of faulting page |
| valid_o | output | 1 | Result valid pulse |
| act_o | output | 2 | Outcome: 0 resume, 1 notify, 2 crash |
| code_o | output | 10 | Crash code |
| param_o | output | 16 | Fault parameter for notify |
| emu_run_o | output | 1 | Emulator was running |

## Verification
The bench goes after the priority edges. A stack flag alongside a memory error must follow the stack rule, and a design that tested the memory path first would notify with a page parameter instead. Out-of-bounds set together with high-half parity must report out-of-bounds, and a reversed order would resume silently. The write-protect fault on the last page must give 16'hBFFF and not 16'hFFFF, which would be mistaken for out-of-bounds. A first-stage fault from a non-emulator task must crash even with notify enabled. Both settings of each control bit are exercised, and a swapped bit would flip resume against crash or notify against crash.

// File: rtl/fault_cls_pkg.sv
package fault_cls_pkg;
  localparam int CODE_W = 10;
  localparam int TASK_W = 4;
  localparam int PAGE_W = 14;
  localparam int PARAM_W = PAGE_W + 2;

  typedef enum logic [1:0] {
    ACT_RESUME = 2'd0,
    ACT_NOTIFY = 2'd1,
    ACT_CRASH  = 2'd2
  } act_e;

  typedef enum logic [1:0] {
    PK_PAGE  = 2'd0,
    PK_WP    = 2'd1,
    PK_OOB   = 2'd2,
    PK_STACK = 2'd3
  } pkind_e;

  localparam logic [CODE_W-1:0] CODE_BRK   = 10'd40;
  localparam logic [CODE_W-1:0] CODE_PAR   = 10'd48;
  localparam logic [CODE_W-1:0] CODE_STK   = 10'd64;
  localparam logic [CODE_W-1:0] CODE_OOB   = 10'd80;
  localparam logic [CODE_W-1:0] CODE_HIPAR = 10'd96;
  localparam logic [CODE_W-1:0] CODE_S22   = 10'd112;
  localparam logic [CODE_W-1:0] CODE_S1    = 10'd220;
  localparam logic [CODE_W-1:0] CODE_S2    = 10'd240;
  localparam logic [CODE_W-1:0] CODE_NONE  = 10'd250;
endpackage

// File: rtl/fc_param_enc.sv
module fc_param_enc
  import fault_cls_pkg::*;
#(
  parameter int PG_W = PAGE_W,
  localparam int PW = PG_W + 2
) (
  input  pkind_e          kind_i,
  input  logic [PG_W-1:0] page_i,
  output logic [PW-1:0]   param_o
);
  always_comb begin
    unique case (kind_i)
      PK_PAGE:  param_o = {2'b00, page_i};
      PK_WP:    param_o = {2'b10, page_i};   // keeps top page apart from all-ones
      PK_OOB:   param_o = '1;
      default:  param_o = {2'b01, {PG_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/fc_mem_path.sv
module fc_mem_path
  import fault_cls_pkg::*;
#(
  parameter int TW = TASK_W
) (
  input  logic              oob_i,
  input  logic              hi_par_i,
  input  logic [1:0]        s2_err_i,
  input  logic [1:0]        s1_err_i,
  input  logic              notify_en_i,
  input  logic              hipar_crash_i,
  input  logic              dirty_i,
  input  logic [TW-1:0]     cur_task_i,
  input  logic [TW-1:0]     flt_task_i,
  output act_e              act_o,
  output logic [CODE_W-1:0] code_o,
  output pkind_e            kind_o
);
  logic [CODE_W-1:0] cur_ext, flt_ext;
  logic any_s1, any_s2;

  assign cur_ext = CODE_W'(cur_task_i);
  assign flt_ext = CODE_W'(flt_task_i);
  assign any_s1  = |s1_err_i;
  assign any_s2  = |s2_err_i;

  always_comb begin
    act_o  = ACT_CRASH;
    code_o = CODE_NONE;
    kind_o = PK_PAGE;
    if (oob_i) begin
      kind_o = PK_OOB;
      if (notify_en_i) act_o = ACT_NOTIFY;
      else             code_o = CODE_OOB + cur_ext;
    end else if (hi_par_i) begin
      if (hipar_crash_i) code_o = CODE_HIPAR + cur_ext;
      else               act_o  = ACT_RESUME;
    end else if (any_s2 && any_s1) begin
      code_o = CODE_S22;
    end else if (any_s2) begin
      code_o = CODE_S2 + flt_ext;
    end else if (any_s1) begin
      if (notify_en_i && (flt_task_i == '0)) begin
        act_o  = ACT_NOTIFY;
        kind_o = dirty_i ? PK_WP : PK_PAGE;
      end else begin
        code_o = CODE_S1 + flt_ext;
      end
    end
  end
endmodule

// File: rtl/fault_classifier.sv
module fault_classifier
  import fault_cls_pkg::*;
#(
  parameter int TW       = TASK_W,
  parameter int PG_W     = PAGE_W,
  parameter int CTRL_W   = 16,
  parameter int HIPAR_BIT = 2,
  parameter int NOTIFY_BIT = 15,
  localparam int PW = PG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stk_err_i,
  input  logic              cs_par_i,
  input  logic              rf_par_i,
  input  logic              mem_err_i,
  input  logic              oob_i,
  input  logic              hi_par_i,
  input  logic [1:0]        s2_err_i,
  input  logic [1:0]        s1_err_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [TW-1:0]     cur_task_i,
  input  logic [TW-1:0]     flt_task_i,
  input  logic [PG_W-1:0]   page_i,
  input  logic              dirty_i,
  output logic              valid_o,
  output logic [1:0]        act_o,
  output logic [CODE_W-1:0] code_o,
  output logic [PW-1:0]     param_o,
  output logic              emu_run_o
);
  logic [3:0]        prim;
  logic              notify_en;
  act_e              mem_act, act_d;
  logic [CODE_W-1:0] mem_code, code_d;
  pkind_e            mem_kind, kind_d;
  logic [PW-1:0]     param_d;

  assign prim      = {stk_err_i, cs_par_i, rf_par_i, mem_err_i};
  assign notify_en = ctrl_i[NOTIFY_BIT];

  fc_mem_path #(.TW(TW)) u_mem (
    .oob_i        (oob_i),
    .hi_par_i     (hi_par_i),
    .s2_err_i     (s2_err_i),
    .s1_err_i     (s1_err_i),
    .notify_en_i  (notify_en),
    .hipar_crash_i(ctrl_i[HIPAR_BIT]),
    .dirty_i      (dirty_i),
    .cur_task_i   (cur_task_i),
    .flt_task_i   (flt_task_i),
    .act_o        (mem_act),
    .code_o       (mem_code),
    .kind_o       (mem_kind)
  );

  // memory-only case first: it is the time-critical one
  always_comb begin
    act_d  = ACT_CRASH;
    code_d = '0;
    kind_d = PK_STACK;
    if (prim == 4'b0001) begin
      act_d  = mem_act;
      code_d = mem_code;
      kind_d = mem_kind;
    end else if (prim == 4'b0000) begin
      code_d = CODE_BRK + CODE_W'(cur_task_i);
    end else if (cs_par_i || rf_par_i) begin
      code_d = CODE_PAR + CODE_W'(prim);
    end else if (notify_en) begin
      act_d = ACT_NOTIFY;
    end else begin
      code_d = CODE_STK;
    end
  end

  fc_param_enc #(.PG_W(PG_W)) u_enc (
    .kind_i (kind_d),
    .page_i (page_i),
    .param_o(param_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      act_o     <= ACT_RESUME;
      code_o    <= '0;
      param_o   <= '0;
      emu_run_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        act_o     <= act_d;
        code_o    <= code_d;
        param_o   <= param_d;
        emu_run_o <= (cur_task_i == '0);
      end
    end
  end

  // R1
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(start_i));
  // R1
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(act_o) && $stable(code_o) && $stable(param_o));
  // R4
  parity_crash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && (cs_par_i || rf_par_i) |=> act_o == ACT_CRASH);
  // R5
  notify_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !notify_en |=> act_o != ACT_NOTIFY);
  // R10
  wp_not_oob_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && prim == 4'b0001 && !oob_i && !hi_par_i && s2_err_i == '0
      && s1_err_i != '0 && dirty_i && notify_en && flt_task_i == '0
    |=> param_o[PW-1 -: 2] == 2'b10);
  // R9
  s1_task_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && prim == 4'b0001 && !oob_i && !hi_par_i && s2_err_i == '0
      && s1_err_i != '0 && flt_task_i != '0
    |=> act_o == ACT_CRASH && code_o >= CODE_S1);
endmodule

// File: tb/fault_classifier_test.sv
module fault_classifier_test;
  logic clk = 0, rst_n = 0, start = 0;
  logic stk = 0, csp = 0, rfp = 0, mem = 0, oob = 0, hip = 0, dirty = 0;
  logic [1:0] s2 = 0, s1 = 0;
  logic [15:0] ctrl = 0;
  logic [3:0] cur = 0, flt = 0;
  logic [13:0] page = 0;
  logic valid, emu;
  logic [1:0] act;
  logic [9:0] code;
  logic [15:0] param;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_classifier uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .stk_err_i(stk), .cs_par_i(csp), .rf_par_i(rfp), .mem_err_i(mem),
    .oob_i(oob), .hi_par_i(hip), .s2_err_i(s2), .s1_err_i(s1),
    .ctrl_i(ctrl), .cur_task_i(cur), .flt_task_i(flt), .page_i(page),
    .dirty_i(dirty), .valid_o(valid), .act_o(act), .code_o(code),
    .param_o(param), .emu_run_o(emu));

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic clr();
    {stk, csp, rfp, mem, oob, hip, dirty} = '0;
    s2 = 0; s1 = 0; ctrl = 0; cur = 0; flt = 0; page = 0;
  endtask

  task automatic go();
    start = 1;
    @(posedge clk); @(negedge clk);
    start = 0;
    chk("R1 valid", valid, 1);
  endtask

  task automatic expect_out(string req, int a, int c, int p);
    chk(req, act, a);
    if (a == 2) chk(req, code, c);
    if (a == 1) chk(req, param, p);
  endtask

  task automatic t_reset();
    chk("R1 reset valid", valid, 0);
    chk("R1 reset act", act, 0);
    chk("R1 reset code", code, 0);
  endtask

  task automatic t_break();
    clr(); cur = 4'd5; go();
    expect_out("R3 breakpoint", 2, 45, 0);
    chk("R12 emu flag", emu, 0);
    @(negedge clk);
    chk("R1 pulse drop", valid, 0);
    chk("R1 hold", code, 45);
  endtask

  task automatic t_parity();
    clr(); csp = 1; stk = 1; mem = 1; ctrl[15] = 1; go();
    expect_out("R4 cs+stk+mem", 2, 48 + 4'b1101, 0);
    clr(); rfp = 1; go();
    expect_out("R4 rf only", 2, 48 + 2, 0);
  endtask

  task automatic t_stack();
    clr(); stk = 1; ctrl[15] = 1; go();
    expect_out("R5 stack notify", 1, 0, 16'h4000);
    chk("R12 emu flag", emu, 1);
    clr(); stk = 1; go();
    expect_out("R5 stack crash", 2, 64, 0);
    clr(); stk = 1; mem = 1; s1 = 1; ctrl[15] = 1; page = 14'h12; go();
    expect_out("R2 stack over mem", 1, 0, 16'h4000);
  endtask

  task automatic t_oob();
    clr(); mem = 1; oob = 1; hip = 1; ctrl[15] = 1; go();
    expect_out("R6 oob notify", 1, 0, 16'hFFFF);
    clr(); mem = 1; oob = 1; cur = 3; go();
    expect_out("R6 oob crash", 2, 83, 0);
  endtask

  task automatic t_hipar();
    clr(); mem = 1; hip = 1; s2 = 2'b01; cur = 7; go();
    expect_out("R7 hipar resume", 0, 0, 0);
    clr(); mem = 1; hip = 1; ctrl[2] = 1; cur = 7; go();
    expect_out("R7 hipar crash", 2, 103, 0);
  endtask

  task automatic t_stage2();
    clr(); mem = 1; s2 = 2'b10; s1 = 2'b01; go();
    expect_out("R8 s2+s1", 2, 112, 0);
    clr(); mem = 1; s2 = 2'b01; flt = 9; go();
    expect_out("R8 s2 only", 2, 249, 0);
  endtask

  task automatic t_stage1();
    clr(); mem = 1; s1 = 2'b10; flt = 4'd6; ctrl[15] = 1; go();
    expect_out("R9 io task", 2, 226, 0);
    clr(); mem = 1; s1 = 2'b01; go();
    expect_out("R9 notify off", 2, 220, 0);
    clr(); mem = 1; s1 = 2'b01; ctrl[15] = 1; page = 14'h0ABC; go();
    expect_out("R10 page fault", 1, 0, 16'h0ABC);
    clr(); mem = 1; s1 = 2'b11; ctrl[15] = 1; dirty = 1; page = 14'h3FFF; go();
    expect_out("R10 wp top page", 1, 0, 16'hBFFF);
  endtask

  task automatic t_none();
    clr(); mem = 1; go();
    expect_out("R11 none", 2, 250, 0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_break();
    t_parity();
    t_stack();
    t_oob();
    t_hipar();
    t_stage2();
    t_stage1();
    t_none();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule